// File: doc/BRIEF.md
# Alarm-Driven Power-Enable Controller

This block sits in the always-on timekeeping domain and drives the enable line of an external power regulator. Software arms a second alarm and turns on power control. When that alarm's match pulse arrives, the enable line drops and the rest of the system powers down. Power comes back when the main alarm fires, or when one of four external wakeup pins reaches its active level.

Each wakeup pin has its own enable bit and its own polarity bit. Polarity defaults to active-low. The pins pass through a two-stage synchronizer before they are used. A sticky flag records every armed second-alarm event, and software clears it by writing a one to it. Turning power control off forces the enable line high. This is always a way out of the OFF state.

Top module: `pwr_alarm_ctl`

## Requirements
- R1: After reset, `pwr_en` is 1 and `alarm2_flag` is 0. Power control and all wakeup enables are off. All four polarity bits are 1 (active-low).
- R2: The interrupt-enable register at 0x48 holds the arm bit at bit 4. A high `alarm2_match` with arm set raises `alarm2_flag` at the next clock edge. With arm clear, `alarm2_match` changes neither `alarm2_flag` nor `pwr_en`.
- R3: Writing a 1 to bit 7 of the status register at 0x44 clears `alarm2_flag` at that edge. Writing 0 leaves it unchanged. An armed match in the same cycle as the clear keeps the flag set.
- R4: The power register at 0x98 holds the control-enable bit at bit 16. With that bit set, `pwr_en` high and an armed match, `pwr_en` goes low at the next edge.
- R5: With bit 16 clear, an armed match still sets the flag but leaves `pwr_en` at 1.
- R6: While `pwr_en` is low, a high `main_alarm` returns `pwr_en` to 1 at the next edge.
- R7: In the power register, bit i (0 to 3) enables wakeup pin i. Bit 4+i sets that pin's polarity: 1 means active when low, 0 means active when high. While off, an enabled pin held at its active level returns `pwr_en` to 1 on the third edge after the pin changes.
- R8: A wakeup pin that is disabled, or held at its inactive level, leaves `pwr_en` low.
- R9: A write that clears bit 16 while `pwr_en` is low makes `pwr_en` 1 on the second edge after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of the always-on domain |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register byte offset |
| wr_data | input | 32 | Register write data |
| alarm2_match | input | 1 | Second-alarm match pulse |
| main_alarm | input | 1 | Main alarm event |
| wake_pins | input | 4 | Asynchronous external wakeup pins |
| pwr_en | output | 1 | Power-enable to the external regulator, 1 = ON |
| alarm2_flag | output | 1 | Sticky armed second-alarm event flag |

## Verification
Alarm inputs, main-alarm inputs and status writes act at the first edge after they are driven. A wakeup pin acts at the third edge, because of the two synchronizer stages. A control write that forces power on acts at the second edge. The bench drives every input on a falling edge. It then waits exactly that number of rising edges and samples on the next falling edge. The pin sweep waits four cycles so that the synchronizer settles before each check. Each pin is tested with every combination of enable, polarity and level.

// File: rtl/pwr_alarm_ctl.sv
module pwr_alarm_ctl #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int NUM_WAKE = 4,
  parameter logic [ADDR_W-1:0] STAT_OFS = 8'h44,
  parameter logic [ADDR_W-1:0] IEN_OFS  = 8'h48,
  parameter logic [ADDR_W-1:0] PWR_OFS  = 8'h98,
  parameter int CTL_BIT  = 16,
  parameter int ARM_BIT  = 4,
  parameter int FLAG_BIT = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              alarm2_match,
  input  logic              main_alarm,
  input  logic [NUM_WAKE-1:0] wake_pins,
  output logic              pwr_en,
  output logic              alarm2_flag
);
  localparam int POL_LSB = NUM_WAKE;

  logic [NUM_WAKE-1:0] wen_q, pol_q, sync1_q, sync2_q;
  logic ctl_q, arm_q, flag_q, pwr_q;
  logic unused_bits;

  wire pwr_wr  = wr_en && (wr_addr == PWR_OFS);
  wire ien_wr  = wr_en && (wr_addr == IEN_OFS);
  wire stat_wr = wr_en && (wr_addr == STAT_OFS);
  wire a2_evt  = alarm2_match && arm_q;
  wire wake_hit = |((sync2_q ^ pol_q) & wen_q);

  assign unused_bits = ^wr_data;
  assign pwr_en      = pwr_q;
  assign alarm2_flag = flag_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= wake_pins;
      sync2_q <= sync1_q;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wen_q <= '0;
      pol_q <= '1;
      ctl_q <= 1'b0;
      arm_q <= 1'b0;
    end else begin
      if (pwr_wr) begin
        wen_q <= wr_data[NUM_WAKE-1:0];
        pol_q <= wr_data[POL_LSB +: NUM_WAKE];
        ctl_q <= wr_data[CTL_BIT];
      end
      if (ien_wr) arm_q <= wr_data[ARM_BIT];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                           flag_q <= 1'b0;
    else if (a2_evt)                      flag_q <= 1'b1;
    else if (stat_wr && wr_data[FLAG_BIT]) flag_q <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                                   pwr_q <= 1'b1;
    else if (!ctl_q)                              pwr_q <= 1'b1;
    else if (pwr_q && a2_evt)                     pwr_q <= 1'b0;
    else if (!pwr_q && (wake_hit || main_alarm))  pwr_q <= 1'b1;

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    a2_evt |=> alarm2_flag); // R2
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && wr_data[FLAG_BIT] && !a2_evt) |=> !alarm2_flag); // R3
  AST_OFF_ON_ALARM2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q && pwr_en && a2_evt) |=> !pwr_en); // R4
  AST_ONLY_ALARM2_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_en) |-> $past(a2_evt && ctl_q)); // R5
  AST_WAKE_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q && !pwr_en && (wake_hit || main_alarm)) |=> pwr_en); // R6
  AST_FORCE_ON: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_q |=> pwr_en); // R9
endmodule

// File: tb/sim_pwr_alarm_ctl.sv
module sim_pwr_alarm_ctl;
  localparam logic [7:0] STAT = 8'h44, IEN = 8'h48, PWR = 8'h98;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic alarm2_match = 1'b0, main_alarm = 1'b0;
  logic [3:0] wake_pins = 4'hF;
  logic pwr_en, alarm2_flag;
  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  pwr_alarm_ctl u0 (.clk, .rst_n, .wr_en, .wr_addr, .wr_data, .alarm2_match,
                    .main_alarm, .wake_pins, .pwr_en, .alarm2_flag);

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse_a2();
    @(negedge clk); alarm2_match = 1'b1;
    @(negedge clk); alarm2_match = 1'b0;
  endtask

  task automatic pulse_main();
    @(negedge clk); main_alarm = 1'b1;
    @(negedge clk); main_alarm = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #200000;
    failures++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle(2);
    rst_n = 1'b1;
    idle(1);
    chk("R1 pwr_en reset", pwr_en, 1'b1);
    chk("R1 flag reset", alarm2_flag, 1'b0);

    // R2: unarmed match ignored
    pulse_a2();
    chk("R2 unarmed flag", alarm2_flag, 1'b0);
    chk("R2 unarmed pwr", pwr_en, 1'b1);
    // R5: armed, control disabled
    wr(IEN, 32'h10);
    pulse_a2();
    chk("R2 armed flag", alarm2_flag, 1'b1);
    chk("R5 no ctl pwr", pwr_en, 1'b1);
    // R3: write 0 keeps, write 1 clears
    wr(STAT, 32'h00);
    chk("R3 write0 keeps", alarm2_flag, 1'b1);
    wr(STAT, 32'h80);
    chk("R3 w1c clears", alarm2_flag, 1'b0);
    // R3: set wins over clear
    @(negedge clk); wr_en = 1'b1; wr_addr = STAT; wr_data = 32'h80; alarm2_match = 1'b1;
    @(negedge clk); wr_en = 1'b0; alarm2_match = 1'b0;
    chk("R3 set wins", alarm2_flag, 1'b1);
    wr(STAT, 32'h80);

    // R4 / R6
    wr(PWR, 32'h1_00F0);
    idle(1);
    pulse_a2();
    chk("R4 off on alarm2", pwr_en, 1'b0);
    pulse_a2();
    chk("R4 stays off", pwr_en, 1'b0);
    idle(3);
    chk("R8 no wake stays off", pwr_en, 1'b0);
    pulse_main();
    chk("R6 main alarm on", pwr_en, 1'b1);

    // R9: clearing control bit forces on after two edges
    pulse_a2();
    chk("R9 pre off", pwr_en, 1'b0);
    @(negedge clk); wr_en = 1'b1; wr_addr = PWR; wr_data = 32'h0_00F0;
    @(negedge clk); wr_en = 1'b0;
    chk("R9 not yet", pwr_en, 1'b0);
    @(negedge clk);
    chk("R9 forced on", pwr_en, 1'b1);

    // R7 / R8 sweep: pin, enable, polarity, level
    for (int p = 0; p < 4; p++)
      for (int en = 0; en < 2; en++)
        for (int pol = 0; pol < 2; pol++)
          for (int lvl = 0; lvl < 2; lvl++) begin
            logic [31:0] d;
            logic act_lvl, exp;
            d = 32'h1_0000 | (32'(en) << p);
            for (int q = 0; q < 4; q++)
              if (q != p) d[4+q] = 1'b1;
            d[4+p] = pol[0];
            act_lvl = ~pol[0];
            wake_pins = 4'hF;
            wake_pins[p] = ~act_lvl;
            wr(PWR, d);
            idle(4);
            pulse_a2();
            chk("R4 sweep off", pwr_en, 1'b0);
            @(negedge clk); wake_pins[p] = lvl[0];
            exp = (en == 1) && (lvl[0] == act_lvl);
            @(negedge clk); @(negedge clk);
            chk("R7 not before sync", pwr_en, 1'b0);
            @(negedge clk);
            chk(exp ? "R7 wake on" : "R8 wake ignored", pwr_en, exp);
            wake_pins[p] = ~act_lvl;
            idle(3);
            if (!pwr_en) pulse_main();
            wr(STAT, 32'h80);
          end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule